// File: doc/BRIEF.md
# Event and cycle counter bank with overflow interrupt

This block counts hardware events for performance analysis. It holds a parameterised number of 32-bit event counters and one dedicated 32-bit cycle counter. Each event counter has a type register that picks which pulse on the `evt_i` vector it counts, and that also carries privilege filter bits. Counting is qualified by the privilege level on `priv_i`. The cycle counter counts clocks. It can be slowed to one step per 64 qualifying clocks, and it can be stopped while debug is prohibited.

Software reaches the block through a flat register port. A write takes effect at the clock edge. A read is combinational from the current address. The event counters are reached indirectly through a select register. Counter enables and interrupt enables are set/clear register pairs. Overflow flags are write-one-to-clear. In every 32-bit bitmap, event counter n sits at bit n and the cycle counter sits at bit 31. One interrupt output combines all flags that are enabled.

Register addresses (`reg_addr_i`): 0 control, 1 enable-set, 2 enable-clear, 3 irq-enable-set, 4 irq-enable-clear, 5 overflow flags, 6 select, 7 selected counter value, 8 selected counter type, 9 cycle counter value.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, every counter, type register, enable mask, irq-enable mask, overflow flag and stored control bit is zero. Reading the control register then returns NUM_CNT in bits 15:11 and zero in all other bits.
- R2: Bits 0 (global run), 3 (cycle divide-by-64), 4 (export request) and 5 (stop cycle counter while `dbg_prohibit_i`) of the control register are stored. Writing bit 1 zeroes all event counters at that edge. Writing bit 2 zeroes the cycle counter and its prescaler at that edge. Bits 1 and 2 always read back as zero.
- R3: A write to address 1 or 3 sets the enable or irq-enable bits where the write data is one. A write to address 2 or 4 clears them. Reading either address of a pair returns the mask. Bits NUM_CNT..30 never become set.
- R4: An event counter advances by one at an edge only when all of these hold in that cycle: control bit 0 is set, its enable bit is set, the filter passes, and `evt_i[type[9:0]]` is high. The new value is readable after that edge.
- R5: Type event number 0x11 counts every clock, whatever `evt_i` holds. Event number 0x00 counts pulses on `evt_i[0]`, which is the software increment.
- R6: Privilege filter. Type bit 31 blocks counting at level 1. Bit 30 blocks counting at level 0. Bit 27 is required to count at level 2. Event counters never count at level 3.
- R7: A type register keeps only bits 31, 30, 27 and 9:0 of the written data. All other bits read as zero.
- R8: Address 6 stores a 5-bit counter number, and addresses 7 and 8 then access that counter and its type. For a number of NUM_CNT or more, writes to 7 and 8 change nothing and reads return zero.
- R9: A counter that steps from 0xFFFFFFFF wraps to zero and sets its overflow flag (bit n, or bit 31 for the cycle counter). Address 5 reads the flags. Writing a one clears a flag and writing a zero leaves it. A wrap in the same cycle as the clear keeps the flag set.
- R10: `irq_o` is high exactly while some overflow flag and its irq-enable bit are both set.
- R11: The cycle counter advances every clock while control bit 0 and enable bit 31 are set, unless control bit 5 is set and `dbg_prohibit_i` is high. With bit 3 set, it advances only on every 64th such clock. Address 9 reads and writes it directly.
- R12: A register write to a counter at an edge wins over a count at the same edge. The written value is held, and counting resumes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| evt_i | input | EVT_W | One-cycle event pulses, indexed by event number |
| priv_i | input | 2 | Current privilege level 0..3 |
| dbg_prohibit_i | input | 1 | Debug-prohibited indication |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
A wrong count or a missed increment stays hidden in a counter until software reads that counter. The bench therefore reads every counter back after each stimulus window and compares it with a model built from the requirements. A lost or late wrap shows up on the flag register and on `irq_o` in the cycle right after the wrapping edge. So flags and the interrupt are checked straight after each wrap, and the clear is checked with both one and zero write data. Prescaler and filter faults only show up as counts that are off by a known amount, so those windows use exact clock counts.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned EVNUM_W = 10;
  localparam logic [EVNUM_W-1:0] EV_CYCLES = 10'h011;
  localparam logic [31:0] TYPE_KEEP = 32'hC800_03FF;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_EN_SET = 4'd1,
    A_EN_CLR = 4'd2,
    A_IE_SET = 4'd3,
    A_IE_CLR = 4'd4,
    A_OVF    = 4'd5,
    A_SEL    = 4'd6,
    A_DATA   = 4'd7,
    A_TYPE   = 4'd8,
    A_CYC    = 4'd9
  } reg_addr_e;

  typedef struct packed {
    logic dp;     // stop cycle counter while debug prohibited
    logic xport;  // export request, stored only
    logic div64;  // cycle prescale
    logic run;    // global enable
  } ctrl_t;

  // privilege filter taken from a type register
  function automatic logic priv_allows(logic [31:0] typ, logic [1:0] lvl);
    case (lvl)
      2'd0:    return !typ[30];
      2'd1:    return !typ[31];
      2'd2:    return typ[27];
      default: return 1'b0;
    endcase
  endfunction

  // increment with carry out: {wrap, next}
  function automatic logic [CNT_W:0] bump(logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int unsigned EVT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             type_we_i,
  input  logic             cnt_we_i,
  input  logic [31:0]      wdata_i,
  input  logic             zero_i,
  input  logic             run_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [1:0]       priv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [31:0]      type_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      type_q;
  logic             ev_fire;
  logic             inc;
  logic [CNT_W:0]   nxt;

  always_comb begin
    ev_fire = 1'b0;
    for (int k = 0; k < EVT_W; k++) begin
      if (type_q[EVNUM_W-1:0] == EVNUM_W'(k)) ev_fire = evt_i[k];
    end
    if (type_q[EVNUM_W-1:0] == EV_CYCLES) ev_fire = 1'b1;
  end

  assign nxt    = bump(cnt_q);
  assign inc    = run_i && ev_fire && priv_allows(type_q, priv_i) && !cnt_we_i && !zero_i;
  assign wrap_o = inc && nxt[CNT_W];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else begin
      if (type_we_i) type_q <= wdata_i & TYPE_KEEP;
      if (zero_i)        cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i;
      else if (inc)      cnt_q <= nxt[CNT_W-1:0];
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = type_q;
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
  import pmu_pkg::*;
#(
  parameter int unsigned PRESCALE = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [31:0]      wdata_i,
  input  logic             zero_i,
  input  logic             run_i,
  input  logic             div_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inc_o,
  output logic             wrap_o
);
  localparam int unsigned PS_W = $clog2(PRESCALE);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  ps_q;
  logic             tick;
  logic [CNT_W:0]   nxt;

  assign tick   = div_i ? (ps_q == PS_LAST) : 1'b1;
  assign nxt    = bump(cnt_q);
  assign inc_o  = run_i && tick && !cnt_we_i && !zero_i;
  assign wrap_o = inc_o && nxt[CNT_W];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ps_q  <= '0;
    end else begin
      if (zero_i)             ps_q <= '0;
      else if (run_i && div_i) ps_q <= (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
      if (zero_i)        cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i;
      else if (inc_o)    cnt_q <= nxt[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned EVT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [1:0]       priv_i,
  input  logic             dbg_prohibit_i,
  output logic             irq_o
);
  localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << NUM_CNT) - 32'd1);

  ctrl_t       ctrl_q;
  logic [31:0] en_q, ie_q, ovf_q, ovf_set;
  logic [4:0]  sel_q;
  logic        sel_ok;
  logic        wr_ctrl, wr_data, wr_type, wr_cyc;
  logic        zero_evt, zero_cyc;
  logic        cyc_run, cyc_inc, cyc_wrap;
  logic [CNT_W-1:0] cyc_cnt;
  logic [CNT_W-1:0] evt_cnt  [NUM_CNT];
  logic [31:0]      evt_type [NUM_CNT];
  logic [NUM_CNT-1:0] evt_wrap;

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_data  = reg_wr_i && (reg_addr_i == A_DATA) && sel_ok;
  assign wr_type  = reg_wr_i && (reg_addr_i == A_TYPE) && sel_ok;
  assign wr_cyc   = reg_wr_i && (reg_addr_i == A_CYC);
  assign zero_evt = wr_ctrl && reg_wdata_i[1];
  assign zero_cyc = wr_ctrl && reg_wdata_i[2];
  assign sel_ok   = 32'(sel_q) < NUM_CNT;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmu_evt_counter #(.EVT_W(EVT_W)) u_evt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .type_we_i(wr_type && (sel_q == 5'(i))),
      .cnt_we_i (wr_data && (sel_q == 5'(i))),
      .wdata_i  (reg_wdata_i),
      .zero_i   (zero_evt),
      .run_i    (ctrl_q.run && en_q[i]),
      .evt_i    (evt_i),
      .priv_i   (priv_i),
      .cnt_o    (evt_cnt[i]),
      .type_o   (evt_type[i]),
      .wrap_o   (evt_wrap[i])
    );
  end

  assign cyc_run = ctrl_q.run && en_q[31] && !(ctrl_q.dp && dbg_prohibit_i);

  pmu_cycle_counter #(.PRESCALE(64)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_we_i(wr_cyc),
    .wdata_i (reg_wdata_i),
    .zero_i  (zero_cyc),
    .run_i   (cyc_run),
    .div_i   (ctrl_q.div64),
    .cnt_o   (cyc_cnt),
    .inc_o   (cyc_inc),
    .wrap_o  (cyc_wrap)
  );

  always_comb begin
    ovf_set = '0;
    ovf_set[NUM_CNT-1:0] = evt_wrap;
    ovf_set[31] = cyc_wrap;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= '0;
      ie_q   <= '0;
      ovf_q  <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= {reg_wdata_i[5], reg_wdata_i[4], reg_wdata_i[3], reg_wdata_i[0]};
      if (reg_wr_i && reg_addr_i == A_EN_SET) en_q <= en_q | (reg_wdata_i & IMPL_MASK);
      if (reg_wr_i && reg_addr_i == A_EN_CLR) en_q <= en_q & ~reg_wdata_i;
      if (reg_wr_i && reg_addr_i == A_IE_SET) ie_q <= ie_q | (reg_wdata_i & IMPL_MASK);
      if (reg_wr_i && reg_addr_i == A_IE_CLR) ie_q <= ie_q & ~reg_wdata_i;
      if (reg_wr_i && reg_addr_i == A_SEL) sel_q <= reg_wdata_i[4:0];
      ovf_q <= (ovf_q & ~((reg_wr_i && reg_addr_i == A_OVF) ? reg_wdata_i : 32'd0)) | ovf_set;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: reg_rdata_o = {16'd0, 5'(NUM_CNT), 5'd0, ctrl_q.dp, ctrl_q.xport,
                             ctrl_q.div64, 2'b00, ctrl_q.run};
      A_EN_SET, A_EN_CLR: reg_rdata_o = en_q;
      A_IE_SET, A_IE_CLR: reg_rdata_o = ie_q;
      A_OVF:  reg_rdata_o = ovf_q;
      A_SEL:  reg_rdata_o = {27'd0, sel_q};
      A_DATA: for (int i = 0; i < NUM_CNT; i++) if (sel_q == 5'(i)) reg_rdata_o = evt_cnt[i];
      A_TYPE: for (int i = 0; i < NUM_CNT; i++) if (sel_q == 5'(i)) reg_rdata_o = evt_type[i];
      A_CYC:  reg_rdata_o = cyc_cnt;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(ovf_q & ie_q);
endmodule

// File: rtl/pmu_counter_unit_checker.sv
module pmu_counter_unit_checker #(
  parameter int unsigned NUM_CNT = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_o,
  input logic [31:0] ovf_q,
  input logic [31:0] ovf_set,
  input logic [31:0] en_q,
  input logic [31:0] ie_q,
  input logic        ctrl_run,
  input logic        ctrl_div,
  input logic [31:0] cyc_cnt,
  input logic        cyc_inc,
  input logic        cyc_we,
  input logic        cyc_zero,
  input logic        evt_zero,
  input logic [31:0] evt0_cnt
);
  localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << NUM_CNT) - 32'd1);

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_set != 32'd0) |=> ((ovf_q & $past(ovf_set)) == $past(ovf_set))); // R9

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_q != 32'd0)); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == 32'd0) |-> !irq_o); // R10

  AST_UNIMPL_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q | ie_q | ovf_q) & ~IMPL_MASK) == 32'd0); // R3

  AST_CYC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_run && !cyc_we && !cyc_zero) |=> $stable(cyc_cnt)); // R11

  AST_PRESCALE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_div && cyc_inc) |=> !(ctrl_div && cyc_inc)); // R11

  AST_EVT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_zero |=> (evt0_cnt == 32'd0)); // R2
endmodule

bind pmu_counter_unit pmu_counter_unit_checker #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .ovf_q   (ovf_q),
  .ovf_set (ovf_set),
  .en_q    (en_q),
  .ie_q    (ie_q),
  .ctrl_run(ctrl_q.run),
  .ctrl_div(ctrl_q.div64),
  .cyc_cnt (cyc_cnt),
  .cyc_inc (cyc_inc),
  .cyc_we  (wr_cyc),
  .cyc_zero(zero_cyc),
  .evt_zero(zero_evt),
  .evt0_cnt(evt_cnt[0])
);

// File: tb/pmu_counter_unit_bench.sv
module pmu_counter_unit_bench;
  localparam int NUM = 4;
  localparam int EW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [EW-1:0] evt = '0;
  logic [1:0]    priv = '0;
  logic          dbg = 1'b0;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmu_counter_unit #(.NUM_CNT(NUM), .EVT_W(EW)) u_pmu_counter_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .evt_i(evt),
    .priv_i(priv), .dbg_prohibit_i(dbg), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(logic [EW-1:0] v);
    evt = v; @(posedge clk); #1; evt = '0;
  endtask

  function automatic bit b_pass(logic [31:0] t, logic [1:0] p);
    if (p == 2'd0) return !t[30];
    if (p == 2'd1) return !t[31];
    if (p == 2'd2) return t[27];
    return 1'b0;
  endfunction

  function automatic bit b_hit(logic [31:0] t, logic [EW-1:0] e, logic [1:0] p);
    int n = int'(t[9:0]);
    bit f = (n == 17) ? 1'b1 : ((n < EW) ? e[n] : 1'b0);
    return f && b_pass(t, p);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m [NUM];
    logic [31:0] t [NUM];
    logic [31:0] ovf_exp;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 reset state
    rd(0, d); chk("R1 ctrl", d, 32'(NUM) << 11);
    rd(5, d); chk("R1 ovf", d, 0);
    rd(1, d); chk("R1 en", d, 0);
    rd(9, d); chk("R1 cyc", d, 0);
    rd(8, d); chk("R1 type", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R3 set/clear pairs
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R3 en set", d, 32'h8000_000F);
    wr(2, 32'h0000_0001); rd(2, d); chk("R3 en clr", d, 32'h8000_000E);
    wr(3, 32'h0000_0030); rd(4, d); chk("R3 ie set", d, 32'h0);
    wr(3, 32'h0000_0006); wr(4, 32'h2); rd(3, d); chk("R3 ie clr", d, 32'h4);
    wr(2, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);

    // R7 type mask, R8 select
    wr(6, 0); wr(8, 32'hFFFF_FFFF); rd(8, d); chk("R7 type mask", d, 32'hC800_03FF);
    wr(6, 7); wr(7, 5); wr(8, 3); rd(7, d); chk("R8 unimpl data", d, 0);
    rd(8, d); chk("R8 unimpl type", d, 0);
    wr(6, 0); rd(7, d); chk("R8 cnt0 untouched", d, 0);

    // R4 basic counting on event 3
    wr(8, 3); wr(1, 1); wr(0, 1);
    repeat (5) pulse(32'h8);
    repeat (2) pulse(32'h10);
    wr(0, 0); rd(7, d); chk("R4 count evt3", d, 5);
    pulse(32'h8); rd(7, d); chk("R4 global off", d, 5);

    // R6 filters
    wr(0, 1);
    wr(8, 32'h8000_0003); priv = 1; repeat (3) pulse(32'h8); rd(7, d); chk("R6 excl L1", d, 5);
    priv = 0; repeat (2) pulse(32'h8); rd(7, d); chk("R6 L0 ok", d, 7);
    wr(8, 32'h4000_0003); pulse(32'h8); rd(7, d); chk("R6 excl L0", d, 7);
    priv = 1; pulse(32'h8); rd(7, d); chk("R6 L1 ok", d, 8);
    wr(8, 3); priv = 2; pulse(32'h8); rd(7, d); chk("R6 L2 no incl", d, 8);
    wr(8, 32'h0800_0003); pulse(32'h8); rd(7, d); chk("R6 L2 incl", d, 9);
    priv = 3; pulse(32'h8); rd(7, d); chk("R6 L3 never", d, 9);
    priv = 0; wr(0, 0);

    // R5 cycle event on counter 1
    wr(6, 1); wr(8, 32'h11); wr(2, 1); wr(1, 2);
    wr(0, 1); repeat (10) @(posedge clk); #1; wr(0, 0);
    rd(7, d); chk("R5 event 0x11", d, 11);

    // R12 write beats count
    wr(0, 1); wr(7, 100); rd(7, d); chk("R12 write wins", d, 100);
    @(posedge clk); #1; rd(7, d); chk("R12 resumes", d, 101);
    wr(0, 0);

    // R9 wrap and flags, R10 irq
    wr(6, 2); wr(8, 32'h11); wr(7, 32'hFFFF_FFFD); wr(2, 2); wr(1, 4);
    wr(0, 1); repeat (2) @(posedge clk); #1; wr(0, 0);
    rd(7, d); chk("R9 wrap value", d, 0);
    rd(5, d); chk("R9 flag set", d, 4);
    chk("R10 irq masked", {31'd0, irq}, 0);
    wr(3, 4); chk("R10 irq on", {31'd0, irq}, 1);
    wr(5, 0); rd(5, d); chk("R9 zero write keeps", d, 4);
    wr(5, 4); rd(5, d); chk("R9 one write clears", d, 0);
    chk("R10 irq off", {31'd0, irq}, 0);
    wr(4, 32'hFFFF_FFFF);

    // R11 cycle counter
    wr(2, 4); wr(1, 32'h8000_0000); wr(9, 0);
    wr(0, 1); repeat (10) @(posedge clk); #1; wr(0, 0);
    rd(9, d); chk("R11 plain count", d, 11);
    wr(0, 4); rd(9, d); chk("R2 cycle zero", d, 0);
    wr(0, 9); repeat (130) @(posedge clk); #1; wr(0, 8);
    rd(9, d); chk("R11 divide by 64", d, 2);
    wr(0, 4); dbg = 1'b1;
    wr(0, 32'h21); repeat (10) @(posedge clk); #1; wr(0, 32'h20);
    rd(9, d); chk("R11 debug stop", d, 0);
    dbg = 1'b0;
    wr(9, 32'hFFFF_FFFF); wr(3, 32'h8000_0000); wr(0, 1); wr(0, 0);
    rd(9, d); chk("R9 cycle wrap", d, 0);
    rd(5, d); chk("R9 cycle flag bit31", d, 32'h8000_0000);
    chk("R10 cycle irq", {31'd0, irq}, 1);
    wr(5, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);

    // R2 control bits
    wr(9, 77); wr(6, 0); wr(0, 2);
    rd(7, d); chk("R2 evt zeroed", d, 0);
    rd(9, d); chk("R2 cycle kept", d, 77);
    rd(0, d); chk("R2 bit1 not stored", d, 32'(NUM) << 11);
    wr(2, 32'hFFFF_FFFF); wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 writable bits", d, (32'(NUM) << 11) | 32'h39);
    wr(0, 0);

    // random counting with filters and wraps (R4 R6 R9)
    for (int i = 0; i < NUM; i++) begin
      t[i] = ($urandom % 8) | ({$urandom} & 32'hC800_0000);
      m[i] = 32'hFFFF_FFC0 + ($urandom % 32);
      wr(6, i); wr(8, t[i]); wr(7, m[i]);
    end
    wr(5, 32'hFFFF_FFFF); wr(1, 32'hF); wr(0, 1);
    ovf_exp = 0;
    for (int c = 0; c < 300; c++) begin
      evt = {$urandom} & 32'hFF;
      priv = 2'($urandom % 4);
      for (int i = 0; i < NUM; i++) begin
        if (b_hit(t[i], evt, priv)) begin
          if (m[i] == 32'hFFFF_FFFF) ovf_exp[i] = 1'b1;
          m[i] = m[i] + 1;
        end
      end
      @(posedge clk); #1;
    end
    evt = '0; wr(0, 0);
    for (int i = 0; i < NUM; i++) begin
      wr(6, i); rd(7, d); chk("R4 random count", d, m[i]);
    end
    rd(5, d); chk("R9 random flags", d, ovf_exp);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule